// File: doc/BRIEF.md
# Cascaded Clock-Manager Reset Sequencer

This block drives the reset inputs of two clock managers in a chain, where the second manager takes its reference clock from the output of the first. It stays idle until the device reports that configuration has finished. It then keeps the first manager in reset for a fixed, parameterised number of cycles and releases it. Next it waits for the first lock flag, and after that it waits out a settling period during which that lock must stay high. Only then does it free the second manager. The wait allows the first output clock to become clean, which matters most when the first manager applies a phase shift and needs longer to lock. Without this wait the second manager may never lock.

A clock manager fails in only one way: it does not lock, or it drops lock. Typical causes are excess input jitter, a frequency change while locking or after locking, and missing reference edges. The block therefore monitors both lock flags. Each wait for lock has a time limit. When lock is lost, or the time limit passes, the block reasserts both resets and restarts from the hold phase. Both lock flags pass through two-flop synchronisers before the block uses them. A single ready output tells downstream logic that both clocks can be used.

Top module: `clkmgr_chain_rstseq`

## Requirements
- R1: After `rst_n` is released with `cfg_done` low, `rst_a` and `rst_b` stay high and `sys_ready` stays low for as long as `cfg_done` stays low.
- R2: `rst_a` stays high for exactly HOLD_CYCLES clock cycles after the first rising edge that samples `cfg_done` high. It falls after edge HOLD_CYCLES+1.
- R3: `rst_b` is never low while `rst_a` is high.
- R4: Each lock flag reaches the state machine through two flops. If `lock_a` rises while the block waits for it and then stays high, `rst_b` falls on the rising edge SETTLE_CYCLES+3 after the change.
- R5: If `lock_a` drops during the settling period, `rst_a` is reasserted and `rst_b` is not released.
- R6: If `lock_a` is not seen within LOCK_TIMEOUT cycles of the release of `rst_a`, then `rst_a` is reasserted. `rst_a` stays low for exactly LOCK_TIMEOUT cycles, and the hold phase runs again.
- R7: While the block waits for the second lock, a synchronised `lock_b` seen on the same edge as the timeout still wins. If `lock_b` is driven high d cycles after the release of `rst_b`, the block reaches ready when d <= LOCK_TIMEOUT-3. Otherwise it reasserts `rst_b` first.
- R8: `sys_ready` is high only in the ready state. It requires both resets to be low and both lock flags to have been high three edges earlier.
- R9: In the ready state, a drop of either lock flag clears `sys_ready` and reasserts both resets on the third rising edge after the drop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| cfg_done | input | 1 | Device configuration complete |
| lock_a | input | 1 | Lock flag of the first clock manager (asynchronous) |
| lock_b | input | 1 | Lock flag of the second clock manager (asynchronous) |
| rst_a | output | 1 | Reset to the first clock manager, active high |
| rst_b | output | 1 | Reset to the second clock manager, active high |
| sys_ready | output | 1 | Both clock managers locked and released |

## Verification
The hardest case to reach from the ports is a `lock_b` that arrives at the timeout boundary of the second wait. There, one edge decides between the ready state and a restart. The stimulus walks a table of arrival delays on both sides of that edge, and it counts cycles from the observed fall of `rst_b`. A restart is recognised when `rst_b` rises again before `sys_ready` is ever seen. A loss of lock inside the short settling window is also hard to reach. It is placed by timing the drop of `lock_a` against the known two-flop latency.

// File: rtl/clkmgr_chain_rstseq.sv
module clkmgr_chain_rstseq #(
  parameter int HOLD_CYCLES   = 1024,
  parameter int SETTLE_CYCLES = 256,
  parameter int LOCK_TIMEOUT  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic lock_a,
  input  logic lock_b,
  output logic rst_a,
  output logic rst_b,
  output logic sys_ready
);

  localparam int MAX_AB = (HOLD_CYCLES > SETTLE_CYCLES) ? HOLD_CYCLES : SETTLE_CYCLES;
  localparam int MAX_C  = (MAX_AB > LOCK_TIMEOUT) ? MAX_AB : LOCK_TIMEOUT;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] HOLD_LAST   = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);
  localparam logic [CW-1:0] TO_LAST     = CW'(LOCK_TIMEOUT - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_WAIT_A, S_SETTLE, S_WAIT_B, S_READY
  } seq_t;

  seq_t          st, st_nx;
  logic [CW-1:0] cnt;
  logic [1:0]    sync_a, sync_b;
  logic          la, lb;

  assign la = sync_a[1];
  assign lb = sync_b[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[0], lock_a};
      sync_b <= {sync_b[0], lock_b};
    end
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:   if (cfg_done) st_nx = S_HOLD;
      S_HOLD:   if (cnt == HOLD_LAST) st_nx = S_WAIT_A;
      S_WAIT_A: begin
        if (la) st_nx = S_SETTLE;
        else if (cnt == TO_LAST) st_nx = S_HOLD;
      end
      S_SETTLE: begin
        if (!la) st_nx = S_HOLD;
        else if (cnt == SETTLE_LAST) st_nx = S_WAIT_B;
      end
      S_WAIT_B: begin
        if (!la) st_nx = S_HOLD;
        else if (lb) st_nx = S_READY;
        else if (cnt == TO_LAST) st_nx = S_HOLD;
      end
      S_READY:  if (!la || !lb) st_nx = S_HOLD;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st || st == S_IDLE || st == S_READY) cnt <= '0;
      else cnt <= cnt + 1'b1;
    end
  end

  assign rst_a     = (st == S_IDLE) || (st == S_HOLD);
  assign rst_b     = !((st == S_WAIT_B) || (st == S_READY));
  assign sys_ready = (st == S_READY);

endmodule

// File: rtl/clkmgr_chain_rstseq_chk.sv
module clkmgr_chain_rstseq_chk #(
  parameter int HOLD_CYCLES = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic lock_a,
  input logic lock_b,
  input logic rst_a,
  input logic rst_b,
  input logic sys_ready
);

  int hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run <= 0;
    else if (!rst_a) hi_run <= 0;
    else if (hi_run < HOLD_CYCLES) hi_run <= hi_run + 1;
  end

  a_r2_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_a) |-> hi_run >= HOLD_CYCLES);

  a_r3_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_b |-> !rst_a);

  a_r4_release_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_b) |-> $past(lock_a, 3));

  a_r8_ready_locks: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ready |-> ($past(lock_a, 3) && $past(lock_b, 3)));

  a_r8_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
    sys_ready |-> (!rst_a && !rst_b));

endmodule

bind clkmgr_chain_rstseq clkmgr_chain_rstseq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_a(lock_a), .lock_b(lock_b),
  .rst_a(rst_a), .rst_b(rst_b), .sys_ready(sys_ready)
);

// File: tb/sim_clkmgr_chain_rstseq.sv
module sim_clkmgr_chain_rstseq;
  localparam int HOLD = 6;
  localparam int SETL = 4;
  localparam int TOUT = 12;
  localparam int NV   = 6;
  // each entry: {lock_b delay after rst_b release, expect ready (1) or restart (0)}
  localparam int VEC [NV][2] = '{'{0,1}, '{4,1}, '{8,1}, '{9,1}, '{10,0}, '{14,0}};

  logic clk = 1'b0, rst_n = 1'b0, cfg_done = 1'b0, lock_a = 1'b0, lock_b = 1'b0;
  logic rst_a, rst_b, sys_ready;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  clkmgr_chain_rstseq #(.HOLD_CYCLES(HOLD), .SETTLE_CYCLES(SETL), .LOCK_TIMEOUT(TOUT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .lock_a(lock_a), .lock_b(lock_b),
    .rst_a(rst_a), .rst_b(rst_b), .sys_ready(sys_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cfg_done = 0; lock_a = 0; lock_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_low(ref logic sig, input int lim);
    for (int i = 0; i < lim && sig; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit saw_ready, saw_restart, rb_ok, ra_back;

    // R1: reset state and idle without cfg_done
    do_reset();
    repeat (20) @(negedge clk);
    check(rst_a && rst_b && !sys_ready, "R1", {rst_a, rst_b, sys_ready}, 3'b110);

    // R2: hold length
    cfg_done = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_a) n++; else break;
    end
    check(n == HOLD, "R2", n, HOLD);
    check(rst_b, "R3", rst_b, 1);

    // R6: first lock never arrives -> timeout restart
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rst_a) n++; else break;
    end
    check(n == TOUT, "R6", n, TOUT);
    check(rst_a && rst_b, "R6", {rst_a, rst_b}, 2'b11);

    // R4: settle latency after lock_a
    wait_low(rst_a, 100);
    lock_a = 1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rst_b) n++; else break;
    end
    check(n == SETL + 2, "R4", n, SETL + 2);
    check(!rst_a, "R3", rst_a, 0);

    // R5: lock_a lost during settle
    do_reset();
    cfg_done = 1;
    wait_low(rst_a, 100);
    lock_a = 1;
    repeat (3) @(negedge clk);
    lock_a = 0;
    rb_ok = 1; ra_back = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!rst_b) rb_ok = 0;
      if (rst_a) ra_back = 1;
    end
    check(rb_ok, "R5", rb_ok, 1);
    check(ra_back, "R5", ra_back, 1);

    // R7: table of lock_b arrival delays around the timeout boundary
    for (int v = 0; v < NV; v++) begin
      do_reset();
      cfg_done = 1;
      wait_low(rst_a, 100);
      lock_a = 1;
      wait_low(rst_b, 100);
      repeat (VEC[v][0]) @(negedge clk);
      lock_b = 1;
      saw_ready = 0; saw_restart = 0;
      for (int i = 0; i < 25; i++) begin
        @(negedge clk);
        if (sys_ready && !saw_restart) saw_ready = 1;
        if (rst_b && !saw_ready) saw_restart = 1;
      end
      check(saw_ready == VEC[v][1][0] && saw_restart == !VEC[v][1][0], "R7",
            {saw_ready, saw_restart}, {VEC[v][1][0], !VEC[v][1][0]});
    end

    // R8: ready with both resets released
    check(sys_ready && !rst_a && !rst_b, "R8", {sys_ready, rst_a, rst_b}, 3'b100);

    // R9: loss of lock_b in ready
    lock_b = 0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_ready) n++; else break;
    end
    check(n == 2, "R9", n, 2);
    check(rst_a && rst_b, "R9", {rst_a, rst_b}, 2'b11);

    // R9: loss of lock_a in ready
    lock_b = 1;
    for (int i = 0; i < 100 && !sys_ready; i++) @(negedge clk);
    check(sys_ready, "R8", sys_ready, 1);
    lock_a = 0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_ready) n++; else break;
    end
    check(n == 2, "R9", n, 2);
    check(rst_a && rst_b, "R9", {rst_a, rst_b}, 2'b11);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule